// File: doc/BRIEF.md
# Triple programmable timer counter

This peripheral holds three independent 16-bit timer channels behind a word-addressed register interface with single-cycle reads and writes. Each channel has its own prescaler, an up or down counter, three match comparators, a six-bit clear-on-read status register with an enable mask, and an interrupt line. The counter wraps either at a programmable interval value or at the full 16-bit range. Software configures a channel, starts it with a control write, and then either polls the count or waits for the interrupt line.

Register words for the three channels are interleaved: every register kind occupies three consecutive 32-bit words, one per channel. The word index divided by three gives the register kind, and the remainder gives the channel. Read data is combinational from the address and strobe. A status read returns the bits and clears them at the clock edge that closes the access.

Top module: `ttc_triple`

## Requirements
- R1: Byte address bits [7:2] form a word index W; W/3 selects the kind and W%3 the channel. Kind bases are clock config 0x00, control 0x0C, count 0x18, interval 0x24, match A 0x30, match B 0x3C, match C 0x48, status 0x54, enable mask 0x60, event config 0x6C, event count 0x78. Clock config and mask keep bits [5:0], event config bits [2:0], interval and match registers bits [15:0].
- R2: After reset, control reads 0x21 (counting halted) on every channel, every other register reads 0, and all interrupt lines are low.
- R3: Clock config bit 0 enables the prescaler and bits [4:1] hold N. With the prescaler on, the count steps once every 2^(N+1) clocks after a start; with it off, the count steps on every clock.
- R4: Control bits are 0 halt, 1 interval wrap, 2 count down, 3 match enable, 4 restart; bits [5:0] are stored except bit 4, which reads 0. A control write with bit 4 set zeroes the count and the prescaler at that edge. A control write governs counting from the next edge.
- R5: Counting up steps from the top of the range to 0; counting down steps from 0 to the top. The top is the interval value in interval mode and 0xFFFF otherwise. A halted channel holds its count.
- R6: A wrap sets status bit 0 in interval mode and status bit 4 in full-range mode. Status bit 5 is never set by the counter.
- R7: With match enable set, a step that lands the count on match A, B or C sets status bit 1, 2 or 3. A match value above the current top never fires. With match enable clear no match bit is set.
- R8: A status read returns the bits and clears them. A bit set by the counter in the clearing cycle survives. Writes to the status register have no effect.
- R9: A channel's interrupt line is high exactly when some status bit and the corresponding mask bit are both set.
- R10: The count and event count registers ignore writes; event count reads 0. Words at or above 0x84 read 0 and ignore writes.
- R11: Channels are independent: an access to one channel leaves the others unchanged, and each channel drives only its own interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; qualifies status clear |
| rdata | output | 32 | Combinational read data |
| irq | output | 3 | Interrupt line per channel |

## Verification
A control write takes effect at its own clock edge, so after a start at edge E the count reflects exactly k steps when it is sampled k edges later. Each step is one clock, or 2^(N+1) clocks with the prescaler on. Read data is combinational, so the bench samples it a moment after driving the address, before the edge that completes the access. The status clear and any new status bit land at that same edge. The interrupt line follows the status register with no extra delay, so it is sampled on the falling edge that follows the setting step. Expected counts come from the step number taken modulo the range length. Expected status values come from listing the steps at which a wrap or a match lands.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 16;
    localparam int PSN_W     = 4;
    localparam int NUM_MATCH = 3;
    localparam int ST_W      = NUM_MATCH + 3;
    localparam int EVC_W     = 3;
    localparam int CFG_W     = 6;
    localparam int PS_CNT_W  = (1 << PSN_W) + 1;
    localparam int NUM_KINDS = 11;

    // status bit positions
    localparam int ST_INTV     = 0;
    localparam int ST_MATCH_LO = 1;
    localparam int ST_OVF      = NUM_MATCH + 1;

    typedef enum logic [3:0] {
        RK_CLK, RK_CTRL, RK_VAL, RK_INTV,
        RK_MATCH0, RK_MATCH1, RK_MATCH2,
        RK_ISR, RK_IEN, RK_EVCTL, RK_EVCNT
    } reg_kind_e;

    typedef struct packed {
        logic             spare;
        logic [PSN_W-1:0] div_exp;
        logic             ps_on;
    } clk_cfg_t;

    typedef struct packed {
        logic spare;
        logic restart;
        logic match_on;
        logic count_down;
        logic wrap_at_intv;
        logic halt;
    } cnt_cfg_t;

    localparam cnt_cfg_t CNT_CFG_RST = '{spare: 1'b1, restart: 1'b0, match_on: 1'b0,
                                        count_down: 1'b0, wrap_at_intv: 1'b0, halt: 1'b1};

    function automatic logic [PS_CNT_W-1:0] ps_limit(clk_cfg_t c);
        return c.ps_on ? ((PS_CNT_W'(2) << c.div_exp) - 1'b1) : '0;
    endfunction

    function automatic reg_kind_e match_kind(int m);
        return reg_kind_e'(4'(int'(RK_MATCH0) + m));
    endfunction

endpackage

// File: rtl/ttc_prescaler.sv
module ttc_prescaler
    import ttc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                restart,
    input  logic [PS_CNT_W-1:0] limit,
    output logic                tick
);

    logic [PS_CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: with a divide ratio above one, two ticks never come back to back
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && limit != '0) |=> (!tick || limit == '0));

endmodule

// File: rtl/ttc_counter.sv
module ttc_counter
    import ttc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 restart,
    input  logic                 wrap_at_intv,
    input  logic                 count_down,
    input  logic                 match_on,
    input  logic [CNT_W-1:0]     interval,
    input  logic [CNT_W-1:0]     match_val [NUM_MATCH],
    output logic [CNT_W-1:0]     value,
    output logic                 wrap_ev,
    output logic [NUM_MATCH-1:0] match_ev
);

    logic [CNT_W-1:0] value_q, limit, nxt;
    logic             at_edge, step;

    always_comb begin
        limit = wrap_at_intv ? interval : '1;
        if (count_down) begin
            at_edge = (value_q == '0);
            nxt     = at_edge ? limit : value_q - 1'b1;
        end else begin
            at_edge = (value_q >= limit);
            nxt     = at_edge ? '0 : value_q + 1'b1;
        end
    end

    assign step    = tick && !restart;
    assign wrap_ev = step && at_edge;
    assign value   = value_q;

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_cmp
        assign match_ev[m] = step && match_on && (match_val[m] <= limit) && (nxt == match_val[m]);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            value_q <= '0;
        end else if (step) begin
            value_q <= nxt;
        end
    end

    // R4: a restart leaves the count at zero
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (rst)
        restart |=> value_q == '0);

    // R5: without a step the count holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(value_q));

    // R5: an upward step below the top adds one
    assert_up_step_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !count_down && value_q < limit) |=> value_q == CNT_W'($past(value_q) + 1'b1));

endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
    import ttc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    clk_cfg_t             clk_q;
    cnt_cfg_t             ctl_q, ctl_raw, ctl_in;
    logic [CNT_W-1:0]     intv_q;
    logic [CNT_W-1:0]     match_q [NUM_MATCH];
    logic [ST_W-1:0]      ien_q, stat_q, set_bits;
    logic [EVC_W-1:0]     evc_q;
    logic [CNT_W-1:0]     value;
    logic                 wrap_ev, tick, hit_wr, rd_clr, restart;
    logic [NUM_MATCH-1:0] match_ev;
    logic                 unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:CNT_W];

    assign hit_wr  = sel && wr_en;
    assign rd_clr  = sel && rd_en && (kind == RK_ISR);

    always_comb begin
        ctl_raw        = cnt_cfg_t'(wdata[CFG_W-1:0]);
        ctl_in         = ctl_raw;
        ctl_in.restart = 1'b0;
    end

    assign restart = hit_wr && (kind == RK_CTRL) && ctl_raw.restart;

    ttc_prescaler u_ps (
        .clk     (clk),
        .rst     (rst),
        .run     (!ctl_q.halt),
        .restart (restart),
        .limit   (ps_limit(clk_q)),
        .tick    (tick)
    );

    ttc_counter u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .restart      (restart),
        .wrap_at_intv (ctl_q.wrap_at_intv),
        .count_down   (ctl_q.count_down),
        .match_on     (ctl_q.match_on),
        .interval     (intv_q),
        .match_val    (match_q),
        .value        (value),
        .wrap_ev      (wrap_ev),
        .match_ev     (match_ev)
    );

    always_comb begin
        set_bits                              = '0;
        set_bits[ST_INTV]                     = wrap_ev && ctl_q.wrap_at_intv;
        set_bits[ST_OVF]                      = wrap_ev && !ctl_q.wrap_at_intv;
        set_bits[ST_MATCH_LO +: NUM_MATCH]    = match_ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q  <= '0;
            ctl_q  <= CNT_CFG_RST;
            intv_q <= '0;
            ien_q  <= '0;
            evc_q  <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= (rd_clr ? '0 : stat_q) | set_bits;
            if (hit_wr) begin
                case (kind)
                    RK_CLK:   clk_q  <= clk_cfg_t'(wdata[CFG_W-1:0]);
                    RK_CTRL:  ctl_q  <= ctl_in;
                    RK_INTV:  intv_q <= wdata[CNT_W-1:0];
                    RK_IEN:   ien_q  <= wdata[ST_W-1:0];
                    RK_EVCTL: evc_q  <= wdata[EVC_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
        always_ff @(posedge clk) begin
            if (rst) begin
                match_q[m] <= '0;
            end else if (hit_wr && kind == match_kind(m)) begin
                match_q[m] <= wdata[CNT_W-1:0];
            end
        end
    end

    assign irq = |(stat_q & ien_q);

    always_comb begin
        case (kind)
            RK_CLK:   rdata = DATA_W'(clk_q);
            RK_CTRL:  rdata = DATA_W'(ctl_q);
            RK_VAL:   rdata = DATA_W'(value);
            RK_INTV:  rdata = DATA_W'(intv_q);
            RK_ISR:   rdata = DATA_W'(stat_q);
            RK_IEN:   rdata = DATA_W'(ien_q);
            RK_EVCTL: rdata = DATA_W'(evc_q);
            default:  rdata = '0;
        endcase
        for (int m = 0; m < NUM_MATCH; m++) begin
            if (kind == match_kind(m)) rdata = DATA_W'(match_q[m]);
        end
    end

    // R8: a status read with nothing new arriving leaves status empty
    assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && set_bits == '0) |=> stat_q == '0);

    // R8: outside a status read, no set bit is lost
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/ttc_triple.sv
module ttc_triple
    import ttc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int WORD_W    = ADDR_W - 2;
    localparam int NUM_WORDS = NUM_KINDS * NUM_CH;

    logic [WORD_W-1:0] word;
    logic              valid;
    reg_kind_e         kind;
    logic [NUM_CH-1:0] sel;
    logic [DATA_W-1:0] ch_rdata [NUM_CH];
    logic              unused_lo;

    assign unused_lo = ^addr[1:0];
    assign word      = addr[ADDR_W-1:2];
    assign valid     = int'(word) < NUM_WORDS;
    assign kind      = reg_kind_e'(4'(word / WORD_W'(NUM_CH)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign sel[c] = valid && (int'(word % WORD_W'(NUM_CH)) == c);

        ttc_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .sel   (sel[c]),
            .wr_en (wr_en),
            .rd_en (rd_en),
            .kind  (kind),
            .wdata (wdata),
            .rdata (ch_rdata[c]),
            .irq   (irq[c])
        );
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[c]) rdata = ch_rdata[c];
        end
    end

    // R10: reads outside the map return zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !valid) |-> rdata == '0);

    // R11: an access reaches at most one channel
    assert_one_channel_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

endmodule

// File: tb/tb_ttc_triple.sv
module tb_ttc_triple;

    localparam int CLK_P = 10;

    localparam logic [31:0] C_HALT = 32'h01, C_INTV = 32'h02, C_DOWN = 32'h04,
                            C_MATCH = 32'h08, C_RST = 32'h10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        wr_en, rd_en;
    logic [31:0] wdata, rdata;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ttc_triple dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] adr(int k, int c);
        return 8'(k * 12 + c * 4);
    endfunction

    function automatic logic [31:0] rb_mask(int k, logic [31:0] w);
        case (k)
            0:       return w & 32'h3F;
            1:       return (w | 32'h1) & 32'h2F;
            3, 4, 5, 6: return w & 32'hFFFF;
            8:       return w & 32'h3F;
            9:       return w & 32'h7;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cfg(int c, logic [31:0] clkv, logic [31:0] intv,
                       logic [31:0] m0, logic [31:0] m1, logic [31:0] m2, logic [31:0] ien);
        logic [31:0] v;
        wr(adr(1, c), C_HALT);
        wr(adr(0, c), clkv);
        wr(adr(3, c), intv);
        wr(adr(4, c), m0);
        wr(adr(5, c), m1);
        wr(adr(6, c), m2);
        wr(adr(8, c), ien);
        rd(adr(7, c), v);
    endtask

    // count sweep: restart, wait k edges, compare against step count modulo range
    task automatic sweep(string req, int c, int L, bit intv, bit down, bit pson, int psn, int kmin, int kmax);
        logic [31:0] v;
        int p, n, m, e;
        cfg(c, {26'b0, 1'b0, 4'(psn), pson}, 32'(L), 0, 0, 0, 0);
        p = pson ? (2 << psn) : 1;
        m = intv ? L + 1 : 65536;
        for (int k = kmin; k <= kmax; k++) begin
            wr(adr(1, c), C_RST | (intv ? C_INTV : 0) | (down ? C_DOWN : 0));
            repeat (k) @(negedge clk);
            rd(adr(2, c), v);
            n = k / p;
            e = down ? (m - (n % m)) % m : n % m;
            chk(req, v, 32'(e));
        end
        wr(adr(1, c), C_HALT);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w;
        addr = '0; wdata = '0; wr_en = 0; rd_en = 0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R2: reset values
        chk("R2 irq", 32'(irq), 0);
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 11; k++) begin
                rd(adr(k, c), v);
                chk("R2", v, (k == 1) ? 32'h21 : 32'h0);
            end

        // R1 R4 R10 R11: interleaved readback with field masks, two patterns
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 3; c++)
                for (int k = 0; k < 11; k++) begin
                    w = (p == 1 ? 32'h5A3C_96E1 : 32'hA5C3_691E) ^ (32'(c) * 32'h0101_0101) ^ (32'(k) * 32'h0001_0203);
                    wr(adr(k, c), (k == 1) ? (w | C_HALT) : w);
                end
            for (int c = 0; c < 3; c++)
                for (int k = 0; k < 11; k++) begin
                    w = (p == 1 ? 32'h5A3C_96E1 : 32'hA5C3_691E) ^ (32'(c) * 32'h0101_0101) ^ (32'(k) * 32'h0001_0203);
                    rd(adr(k, c), v);
                    chk("R1 R4 R10 R11 readback", v, rb_mask(k, w));
                end
        end

        // R10: unmapped words read zero and writes there change nothing
        for (int a = 8'h84; a <= 8'hFC; a += 4) begin
            wr(8'(a), 32'hFFFF_FFFF);
            rd(8'(a), v);
            chk("R10 unmapped", v, 0);
        end
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 11; k++) begin
                w = 32'h5A3C_96E1 ^ (32'(c) * 32'h0101_0101) ^ (32'(k) * 32'h0001_0203);
                rd(adr(k, c), v);
                chk("R10 map intact", v, rb_mask(k, w));
            end
        chk("R9 irq idle", 32'(irq), 0);

        // R5: counting in interval and full-range modes, both directions
        sweep("R5 up interval", 0, 5, 1, 0, 0, 0, 0, 14);
        sweep("R5 down interval", 1, 5, 1, 1, 0, 0, 0, 14);
        sweep("R5 up full", 2, 0, 0, 0, 0, 0, 0, 5);
        sweep("R5 down full", 2, 0, 0, 1, 0, 0, 0, 5);
        // R3: prescaler ratios
        sweep("R3 div2", 0, 3, 1, 0, 1, 0, 0, 20);
        sweep("R3 div8", 1, 4, 1, 1, 1, 2, 0, 50);
        sweep("R3 div128", 2, 0, 0, 0, 1, 6, 127, 128);
        sweep("R3 div128", 2, 0, 0, 0, 1, 6, 255, 256);

        // R5 R6: full-range upward wrap
        cfg(0, 0, 0, 0, 0, 0, 0);
        wr(adr(1, 0), C_RST);
        repeat (65535) @(negedge clk);
        rd(adr(2, 0), v); chk("R5 top", v, 32'hFFFF);
        rd(adr(7, 0), v); chk("R6 overflow bit4", v, 32'h10);
        rd(adr(2, 0), v); chk("R5 wrapped", v, 32'h1);

        // R6: wrap flag by mode and direction
        cfg(1, 0, 2, 0, 0, 0, 0);
        wr(adr(1, 1), C_RST | C_INTV);
        repeat (3) @(negedge clk);
        rd(adr(7, 1), v); chk("R6 interval up bit0", v, 32'h01);
        cfg(1, 0, 2, 0, 0, 0, 0);
        wr(adr(1, 1), C_RST | C_DOWN);
        @(negedge clk);
        rd(adr(7, 1), v); chk("R6 full down bit4", v, 32'h10);
        cfg(1, 0, 2, 0, 0, 0, 0);
        wr(adr(1, 1), C_RST | C_DOWN | C_INTV);
        @(negedge clk);
        rd(adr(7, 1), v); chk("R6 interval down bit0", v, 32'h01);

        // R7: match bits, enable gate, limit gate
        cfg(1, 0, 5, 3, 7, 5, 0);
        wr(adr(1, 1), C_RST | C_INTV | C_MATCH);
        repeat (6) @(negedge clk);
        rd(adr(7, 1), v); chk("R7 interval up matches", v, 32'h0B);
        cfg(1, 0, 5, 3, 7, 5, 0);
        wr(adr(1, 1), C_RST | C_INTV);
        repeat (6) @(negedge clk);
        rd(adr(7, 1), v); chk("R7 match disabled", v, 32'h01);
        cfg(1, 0, 5, 3, 7, 5, 0);
        wr(adr(1, 1), C_RST | C_MATCH);
        repeat (7) @(negedge clk);
        rd(adr(7, 1), v); chk("R7 full range matches", v, 32'h0E);
        cfg(1, 0, 5, 3, 7, 5, 0);
        wr(adr(1, 1), C_RST | C_INTV | C_DOWN | C_MATCH);
        repeat (3) @(negedge clk);
        rd(adr(7, 1), v); chk("R7 interval down matches", v, 32'h0B);
        wr(adr(1, 1), C_HALT);

        // R9 R11: interrupt line and mask
        cfg(2, 0, 5, 3, 7, 5, 32'h02);
        wr(adr(1, 2), C_RST | C_INTV | C_MATCH);
        repeat (2) @(negedge clk);
        chk("R9 before match", 32'(irq), 0);
        @(negedge clk);
        chk("R9 R11 match line", 32'(irq), 32'h4);
        rd(adr(7, 2), v); chk("R8 read value", v, 32'h02);
        chk("R9 after clear", 32'(irq), 0);
        repeat (2) @(negedge clk);
        chk("R9 masked bits", 32'(irq), 0);
        rd(adr(7, 2), v); chk("R9 masked status", v, 32'h09);
        wr(adr(1, 2), C_HALT);

        // R8: set in the clearing cycle survives; writes ignored
        cfg(0, 0, 5, 0, 0, 0, 0);
        wr(adr(1, 0), C_RST | C_INTV);
        repeat (5) @(negedge clk);
        rd(adr(7, 0), v); chk("R8 read before wrap", v, 0);
        wr(adr(7, 0), 32'h3F);
        rd(adr(7, 0), v); chk("R8 set wins over clear", v, 32'h01);
        rd(adr(7, 0), v); chk("R8 cleared", v, 0);

        // R4 R5: halt holds the count; control takes effect from the next edge
        cfg(0, 0, 100, 0, 0, 0, 0);
        wr(adr(1, 0), C_RST | C_INTV);
        repeat (2) @(negedge clk);
        wr(adr(1, 0), C_HALT | C_INTV);
        repeat (10) @(negedge clk);
        rd(adr(2, 0), v); chk("R4 halt hold", v, 32'd3);
        wr(adr(2, 0), 32'h1234);
        rd(adr(2, 0), v); chk("R10 count write ignored", v, 32'd3);
        rd(adr(1, 0), v); chk("R4 restart bit reads 0", v, 32'h03);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule